// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable logic cell. Its behaviour is set entirely by a 36-bit configuration word. The word holds two 16-entry truth tables, called F and G, plus four mode bits. In the default mode each table computes its own arbitrary function of four inputs. A merge mode uses a fifth input to choose between the two tables, which gives any 5-input function. An arithmetic mode sends the carry input into table F as one of its index bits and lets a dedicated majority gate produce the carry output. Each of the two outputs can be taken straight from the logic or from a D flip-flop.

Configuration is shifted in serially on the user clock while a shift enable is high. The oldest configuration bit appears on a serial output. Several cells can therefore be loaded as one long chain. Cells placed side by side are joined carry-out to carry-in to form a ripple adder. The carry leaves the lookup tables out of the carry path.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_shift_en` is high, each clock edge shifts `cfg_din` into bit 0 of the 36-bit configuration word. All other bits move up by one place. `cfg_dout` always shows bit 35. A word sent MSB first therefore ends up with its first bit in bit 35. The word is laid out as follows: bits 35..20 hold table F, bits 19..4 hold table G, bit 3 is merge, bit 2 is arith, bit 1 is reg_x and bit 0 is reg_y.
- R2: While `cfg_shift_en` is low, the configuration word keeps its value. `rst` has no effect on the configuration word.
- R3: When merge and arith are both 0, `out_x` = F[`a_in`] and `out_y` = G[`b_in`]. Here T[i] means bit i of the table, and i is the input read as an unsigned number.
- R4: When merge is 1 and arith is 0, both tables are indexed by `a_in`. `out_x` = G[`a_in`] when `sel5` is 1, and F[`a_in`] when `sel5` is 0. `out_y` = G[`a_in`].
- R5: When arith is 1, `out_x` = F[{`a_in`[3], `carry_in`, `a_in`[1], `a_in`[0]}]. `carry_out` is the majority of `a_in`[0], `a_in`[1] and `carry_in`. arith takes priority over merge.
- R6: When arith is 0, `carry_out` equals `carry_in`.
- R7: When reg_x is 1, `out_x` shows the value its logic had at the last clock edge; when reg_x is 0, it shows the current combinational value. reg_y does the same for `out_y`.
- R8: A synchronous `rst` clears both output flip-flops to 0.
- R9: Four cells chained carry-out to carry-in, each set to arith with F[i] = i[0]^i[1]^i[2], form a correct 4-bit ripple adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the user flip-flops and the configuration shift |
| rst | input | 1 | Synchronous clear of the user flip-flops |
| cfg_shift_en | input | 1 | Shifts the configuration word when high |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Oldest configuration bit, used to chain cells |
| a_in | input | 4 | Index for table F; also the adder operands on bits 0 and 1 |
| b_in | input | 4 | Index for table G in the default mode |
| sel5 | input | 1 | Fifth input, chooses the table in merge mode |
| carry_in | input | 1 | Carry from the neighbouring cell below |
| out_x | output | 1 | X function output, combinational or registered |
| out_y | output | 1 | Y function output, combinational or registered |
| carry_out | output | 1 | Carry to the neighbouring cell above |

## Verification
A single wrong configuration bit shows up at the ports only when an input pattern selects that table entry. For that reason the tables are filled at random and every input pattern is applied, so a bad entry appears on `out_x` or `out_y` within one pass. An error in the shift order misplaces a mode bit, which changes the behaviour of the whole cell at once, or it shows up on `cfg_dout` one edge after the load. A fault in a flip-flop or in the register bypass appears one edge after the input changes. A fault in the carry appears on the chained sum bits above the faulty cell and on the final carry.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_K = 4;
  localparam int TBL_N = 1 << LUT_K;

  typedef struct packed {
    logic [TBL_N-1:0] tbl_f;
    logic [TBL_N-1:0] tbl_g;
    logic             merge;
    logic             arith;
    logic             reg_x;
    logic             reg_y;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (r & (p ^ q));
  endfunction

  function automatic logic [LUT_K-1:0] arith_index(input logic [LUT_K-1:0] a, input logic cin);
    logic [LUT_K-1:0] idx;
    idx    = a;
    idx[2] = cin;
    return idx;
  endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic         dout,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (shift_en) cfg_q <= {cfg_q[W-2:0], din};
  end

  assign dout = cfg_q[W-1];

  // R1
  cfg_shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cfg_q[0] == $past(din));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg_q));
endmodule

// File: rtl/lc_lut4.sv
module lc_lut4 #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tbl,
  input  logic [K-1:0] idx,
  output logic         o
);
  assign o = tbl[idx];
endmodule

// File: rtl/lc_carry.sv
module lc_carry
  import lc_pkg::*;
(
  input  logic arith,
  input  logic op_a,
  input  logic op_b,
  input  logic cin,
  output logic cout
);
  assign cout = arith ? maj3(op_a, op_b, cin) : cin;

  // R5: equal operands generate or kill regardless of carry in
  always_comb begin
    if (arith && (op_a == op_b)) begin
      carry_gen_kill_chk: assert (cout == op_a);
    end
  end
endmodule

// File: rtl/lc_out_reg.sv
module lc_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic use_reg,
  input  logic d,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= d;
  end

  assign q = use_reg ? q_r : d;

  // R7
  reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_r == $past(d));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic [LUT_K-1:0] a_in,
  input  logic [LUT_K-1:0] b_in,
  input  logic             sel5,
  input  logic             carry_in,
  output logic             out_x,
  output logic             out_y,
  output logic             carry_out
);
  logic [CFG_W-1:0] cfg_bits;
  cell_cfg_t        cfg;

  lc_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_shift_en), .din(cfg_din),
    .dout(cfg_dout), .cfg_q(cfg_bits)
  );
  assign cfg = cell_cfg_t'(cfg_bits);

  // index steering: table 0 is F, table 1 is G
  logic                        merge_on;
  logic [1:0][TBL_N-1:0]       tbls;
  logic [1:0][LUT_K-1:0]       idxs;
  logic [1:0]                  lut_o;

  assign merge_on = cfg.merge & ~cfg.arith;
  assign tbls[0]  = cfg.tbl_f;
  assign tbls[1]  = cfg.tbl_g;
  assign idxs[0]  = cfg.arith ? arith_index(a_in, carry_in) : a_in;
  assign idxs[1]  = merge_on ? a_in : b_in;

  for (genvar i = 0; i < 2; i++) begin : g_lut
    lc_lut4 #(.K(LUT_K)) u_lut (.tbl(tbls[i]), .idx(idxs[i]), .o(lut_o[i]));
  end

  // function outputs before the register stage
  logic [1:0] fn_d;
  logic [1:0] fn_q;
  logic [1:0] use_reg;

  assign fn_d[0]    = (merge_on && sel5) ? lut_o[1] : lut_o[0];
  assign fn_d[1]    = lut_o[1];
  assign use_reg[0] = cfg.reg_x;
  assign use_reg[1] = cfg.reg_y;

  for (genvar i = 0; i < 2; i++) begin : g_out
    lc_out_reg u_reg (
      .clk(clk), .rst(rst), .use_reg(use_reg[i]), .d(fn_d[i]), .q(fn_q[i])
    );
  end

  assign out_x = fn_q[0];
  assign out_y = fn_q[1];

  lc_carry u_carry (
    .arith(cfg.arith), .op_a(a_in[0]), .op_b(a_in[1]),
    .cin(carry_in), .cout(carry_out)
  );

  // R4: in merge mode with identical sources, X and Y agree
  merge_y_chk: assert property (@(posedge clk) disable iff (rst)
    (merge_on && sel5 && !cfg.reg_x && !cfg.reg_y) |-> out_x == out_y);
endmodule

// File: tb/lut_cell_bench.sv
module lut_cell_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic       rst = 1;
  logic       sh_en = 0, sh_din = 0;
  logic       dout;
  logic [3:0] a = 0, b = 0;
  logic       s5 = 0, cin = 0;
  logic       ox, oy, cout;

  int checks = 0, errors = 0;
  bit done = 0;

  lut_cell u_lut_cell (
    .clk(clk), .rst(rst), .cfg_shift_en(sh_en), .cfg_din(sh_din), .cfg_dout(dout),
    .a_in(a), .b_in(b), .sel5(s5), .carry_in(cin),
    .out_x(ox), .out_y(oy), .carry_out(cout)
  );

  // four-cell chain
  logic       ch_en = 0, ch_din = 0;
  logic [3:0] ch_a = 0;
  logic       ch_cin = 0;
  logic [4:0] ch_c;
  logic [4:0] ch_d;
  logic [3:0] ch_x, ch_y;
  assign ch_c[0] = ch_cin;
  assign ch_d[0] = ch_din;
  for (genvar i = 0; i < 4; i++) begin : g_ch
    lut_cell u_cell (
      .clk(clk), .rst(rst), .cfg_shift_en(ch_en), .cfg_din(ch_d[i]), .cfg_dout(ch_d[i+1]),
      .a_in({2'b00, ch_a[i], ch_a[i]}), .b_in(4'd0), .sel5(1'b0), .carry_in(ch_c[i]),
      .out_x(ch_x[i]), .out_y(ch_y[i]), .carry_out(ch_c[i+1])
    );
  end

  function automatic logic [35:0] mk(logic [15:0] f, logic [15:0] g,
                                     logic m, logic ar, logic rx, logic ry);
    return {f, g, m, ar, rx, ry};
  endfunction

  function automatic logic ref_x(logic [35:0] c, logic [3:0] ai, logic si, logic ci);
    logic [15:0] f, g;
    f = c[35:20]; g = c[19:4];
    if (c[2]) return f[{ai[3], ci, ai[1], ai[0]}];
    if (c[3]) return si ? g[ai] : f[ai];
    return f[ai];
  endfunction

  function automatic logic ref_y(logic [35:0] c, logic [3:0] ai, logic [3:0] bi);
    logic [15:0] g;
    g = c[19:4];
    return (c[3] && !c[2]) ? g[ai] : g[bi];
  endfunction

  function automatic logic [15:0] sum_tbl();
    logic [15:0] t;
    for (int i = 0; i < 16; i++) t[i] = i[0] ^ i[1] ^ i[2];
    return t;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic load(logic [35:0] c);
    for (int i = 35; i >= 0; i--) begin
      @(negedge clk); sh_en = 1; sh_din = c[i];
    end
    @(negedge clk); sh_en = 0; sh_din = 0;
  endtask

  task automatic drive(logic [3:0] ai, logic [3:0] bi, logic si, logic ci);
    @(negedge clk); a = ai; b = bi; s5 = si; cin = ci; #1;
  endtask

  logic [35:0] cfg;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: serial load order and dout
    cfg = mk(16'($urandom(7)), 16'($urandom()), 0, 0, 0, 0);
    load(cfg);
    chk("R1 dout", dout, cfg[35]);
    for (int ai = 0; ai < 16; ai++) begin
      drive(4'(ai), 4'(15 - ai), 0, 0);
      // R3: plain mode, F by a_in and G by b_in
      chk("R3 x", ox, ref_x(cfg, a, s5, cin));
      chk("R3 y", oy, ref_y(cfg, a, b));
    end

    // R2: shift disabled with toggling data, and rst pulse, leave config intact
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sh_din = ~sh_din;
    end
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R2 dout", dout, cfg[35]);
    for (int i = 0; i < 20; i++) begin
      drive(4'($urandom()), 4'($urandom()), 0, 0);
      chk("R2 x", ox, ref_x(cfg, a, s5, cin));
      chk("R2 y", oy, ref_y(cfg, a, b));
    end

    // R4: merge mode, all 32 combinations of a_in and sel5
    cfg = mk(16'($urandom()), 16'($urandom()), 1, 0, 0, 0);
    load(cfg);
    for (int v = 0; v < 32; v++) begin
      drive(4'(v), 4'($urandom()), v[4], 0);
      chk("R4 x", ox, ref_x(cfg, a, s5, cin));
      chk("R4 y", oy, ref_y(cfg, a, b));
      chk("R6 carry pass", cout, cin);
    end

    // R5: arith mode with random table; arith overrides merge
    cfg = mk(16'($urandom()), 16'($urandom()), 1, 1, 0, 0);
    load(cfg);
    for (int v = 0; v < 32; v++) begin
      drive(4'(v), 4'($urandom()), 1, v[4]);
      chk("R5 x", ox, ref_x(cfg, a, s5, cin));
      chk("R5 carry", cout, (a[0] & a[1]) | (cin & (a[0] ^ a[1])));
    end

    // R6: carry passes through outside arith
    cfg = mk(16'hFFFF, 16'h0, 0, 0, 0, 0);
    load(cfg);
    drive(4'b0011, 0, 0, 0); chk("R6 low", cout, 1'b0);
    drive(4'b0000, 0, 0, 1); chk("R6 high", cout, 1'b1);

    // R7: registered outputs lag by one edge
    cfg = mk(16'($urandom()), 16'($urandom()), 0, 0, 1, 1);
    load(cfg);
    for (int i = 0; i < 16; i++) begin
      logic ex, ey;
      drive(4'($urandom()), 4'($urandom()), 0, 0);
      ex = ref_x(cfg, a, s5, cin); ey = ref_y(cfg, a, b);
      @(posedge clk); #1;
      a = ~a; b = ~b; #1;
      chk("R7 x", ox, ex);
      chk("R7 y", oy, ey);
    end

    // R8: synchronous reset clears registers
    cfg = mk(16'hFFFF, 16'hFFFF, 0, 0, 1, 1);
    load(cfg);
    drive(0, 0, 0, 0);
    @(posedge clk); #1;
    chk("R8 pre x", ox, 1'b1);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R8 x", ox, 1'b0);
    chk("R8 y", oy, 1'b0);
    @(negedge clk); rst = 0;

    // R9: four-cell ripple adder, last cell's word shifted first
    cfg = mk(sum_tbl(), 16'h0, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++)
      for (int i = 35; i >= 0; i--) begin
        @(negedge clk); ch_en = 1; ch_din = cfg[i];
      end
    @(negedge clk); ch_en = 0;
    for (int v = 0; v < 512; v++) begin
      logic [4:0] sum;
      sum = 5'(v[3:0]) + 5'(v[7:4]) + 5'(v[8]);
      @(negedge clk);
      force g_ch[0].u_cell.a_in = {2'b00, v[4], v[0]};
      force g_ch[1].u_cell.a_in = {2'b00, v[5], v[1]};
      force g_ch[2].u_cell.a_in = {2'b00, v[6], v[2]};
      force g_ch[3].u_cell.a_in = {2'b00, v[7], v[3]};
      ch_cin = v[8]; #1;
      chk("R9 sum", ch_x[0], sum[0]);
      chk("R9 sum", ch_x[1], sum[1]);
      chk("R9 sum", ch_x[2], sum[2]);
      chk("R9 sum", ch_x[3], sum[3]);
      chk("R9 cout", ch_c[4], sum[4]);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule